// File: doc/BRIEF.md
# Pilot Identification Tone Classifier

This block decides whether a broadcast carries stereo sound, two-language sound or plain mono sound by timing a low-frequency identification tone. An upstream detector and comparator turn the recovered pilot into a single-bit square wave. The block times that wave between rising edges with a reference clock of known rate and sorts each measured period into one of three classes.

Each tone class has two frequency windows. A narrow acquire window must be met to enter the mode, and a wider hold window keeps the mode once it is reported. This gives hysteresis against slow drift. A class change is published only after it has persisted without interruption. Entering a tone mode takes a long confirmation and dropping back to mono takes a short one, so a weak or unstable input does not make the indicator flicker. If the tone disappears for longer than a timeout, the input counts as "no tone" and qualifies mono.

Top module: `pid_tone_classifier`

## Requirements
- R1: A synchronous reset, sampled high at a clock edge, gives `bcast_o` = 00 and `valid_o` = 0 after that edge. Both stay that way until the first qualification completes.
- R2: `bcast_o` uses 00 for mono, 01 for stereo and 10 for two-language. The code 11 never appears.
- R3: `tone_in` passes through two synchroniser flops. A rising edge first sampled high at edge n is acted on at edge n+2. The period p is the number of clock edges between two successive acted-on rising edges. p lies in a window [Flo, Fhi] Hz when CLK_HZ/Fhi <= p <= CLK_HZ/Flo, using integer division.
- R4: While the block reports mono, or `valid_o` is low, a period gives a stereo candidate only inside 140–160 Hz and a two-language candidate only inside 255–300 Hz. Any other period gives a mono candidate.
- R5: While stereo is reported, a period inside 125–176 Hz keeps stereo. While two-language is reported, a period inside 237–312 Hz keeps two-language. Outside its hold window, the candidate is the other tone class if its acquire window is met, and mono otherwise.
- R6: If no rising edge is acted on for TIMEOUT = CLK_HZ/TIMEOUT_HZ edges, the block raises a tone-absent event once, and that event gives a mono candidate. The next rising edge after that event only re-arms the measurement and produces no period.
- R7: A candidate that differs from the reported state is published a fixed number of edges after the event that started it. For stereo or two-language this is ACQ = (CLK_HZ/1000)*ACQ_MS edges; for mono it is REL = (CLK_HZ/1000)*REL_MS edges. This holds only while no event with another class arrives in between.
- R8: An event whose class equals the reported mode, with `valid_o` high, abandons a pending change. An event of a third class restarts the wait with the new class.
- R9: `valid_o` rises with the first published class and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of rate CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| tone_in | input | 1 | Square-wave identification tone, asynchronous |
| bcast_o | output | 2 | Reported broadcast class (00 mono, 01 stereo, 10 two-language) |
| valid_o | output | 1 | High once a class has been confirmed |

## Verification
The in-module assertions watch, on every cycle, the properties that need no history of the tone. These are: the illegal code 11 never appears; the measurement counter never exceeds its timeout; a tone-absent event disarms the next period; the published class moves only out of a pending confirmation; the valid flag is sticky; and reset clears the outputs. The hysteresis between acquire and hold windows, the exact confirmation delays, cancellation by a matching event and restart by a third class depend on sequences of periods. These only the bench scenarios can show, and the bench's cycle-by-cycle reference model confirms each one at the exact edge.

// File: rtl/pid_pkg.sv
package pid_pkg;

  typedef enum logic [1:0] {
    MODE_MONO   = 2'b00,
    MODE_STEREO = 2'b01,
    MODE_BILING = 2'b10
  } bcast_e;

  // number of reference cycles in one period of a tone of hz
  function automatic int hz_to_cycles(int clk_hz, int hz);
    return clk_hz / hz;
  endfunction

endpackage

// File: rtl/pid_edge_sync.sv
module pid_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  logic [SYNC_STAGES:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {sr_q[SYNC_STAGES-1:0], din};
  end

  assign rise = sr_q[SYNC_STAGES-1] & ~sr_q[SYNC_STAGES];

endmodule

// File: rtl/pid_period_meter.sv
module pid_period_meter #(
  parameter int TO_CYC = 320,
  parameter int CNT_W  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  output logic             period_evt,
  output logic             timeout_evt,
  output logic [CNT_W-1:0] period
);

  localparam logic [CNT_W-1:0] TO_CNT = CNT_W'(TO_CYC);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             silent_q;

  assign period      = cnt_q;
  assign period_evt  = rise & armed_q;
  assign timeout_evt = ~rise & (cnt_q == TO_CNT) & ~silent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      silent_q <= 1'b0;
    end else if (rise) begin
      cnt_q    <= ONE;
      armed_q  <= 1'b1;
      silent_q <= 1'b0;
    end else if (cnt_q == TO_CNT) begin
      if (!silent_q) begin
        silent_q <= 1'b1;
        armed_q  <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TO_CNT); // R6
  AST_TIMEOUT_DISARMS: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |=> !period_evt); // R6

endmodule

// File: rtl/pid_band_classifier.sv
module pid_band_classifier
  import pid_pkg::*;
#(
  parameter int CNT_W         = 9,
  parameter int CLK_HZ        = 1000000,
  parameter int ST_ACQ_LO_HZ  = 140,
  parameter int ST_ACQ_HI_HZ  = 160,
  parameter int ST_HOLD_LO_HZ = 125,
  parameter int ST_HOLD_HI_HZ = 176,
  parameter int BI_ACQ_LO_HZ  = 255,
  parameter int BI_ACQ_HI_HZ  = 300,
  parameter int BI_HOLD_LO_HZ = 237,
  parameter int BI_HOLD_HI_HZ = 312
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  input  logic             timeout,
  input  bcast_e           cur_mode,
  input  logic             cur_valid,
  output bcast_e           cls
);

  // index 0: stereo tone, index 1: two-language tone
  localparam int ACQ_MIN [2]  = '{hz_to_cycles(CLK_HZ, ST_ACQ_HI_HZ),
                                  hz_to_cycles(CLK_HZ, BI_ACQ_HI_HZ)};
  localparam int ACQ_MAX [2]  = '{hz_to_cycles(CLK_HZ, ST_ACQ_LO_HZ),
                                  hz_to_cycles(CLK_HZ, BI_ACQ_LO_HZ)};
  localparam int HOLD_MIN [2] = '{hz_to_cycles(CLK_HZ, ST_HOLD_HI_HZ),
                                  hz_to_cycles(CLK_HZ, BI_HOLD_HI_HZ)};
  localparam int HOLD_MAX [2] = '{hz_to_cycles(CLK_HZ, ST_HOLD_LO_HZ),
                                  hz_to_cycles(CLK_HZ, BI_HOLD_LO_HZ)};

  logic [1:0] in_acq;
  logic [1:0] in_hold;

  for (genvar b = 0; b < 2; b++) begin : g_band
    localparam logic [CNT_W-1:0] A_LO = CNT_W'(ACQ_MIN[b]);
    localparam logic [CNT_W-1:0] A_HI = CNT_W'(ACQ_MAX[b]);
    localparam logic [CNT_W-1:0] H_LO = CNT_W'(HOLD_MIN[b]);
    localparam logic [CNT_W-1:0] H_HI = CNT_W'(HOLD_MAX[b]);
    assign in_acq[b]  = (period >= A_LO) && (period <= A_HI);
    assign in_hold[b] = (period >= H_LO) && (period <= H_HI);
  end

  always_comb begin
    cls = MODE_MONO;
    if (!timeout) begin
      if (cur_valid && cur_mode == MODE_STEREO) begin
        if (in_hold[0])     cls = MODE_STEREO;
        else if (in_acq[1]) cls = MODE_BILING;
      end else if (cur_valid && cur_mode == MODE_BILING) begin
        if (in_hold[1])     cls = MODE_BILING;
        else if (in_acq[0]) cls = MODE_STEREO;
      end else begin
        if (in_acq[0])      cls = MODE_STEREO;
        else if (in_acq[1]) cls = MODE_BILING;
      end
    end
  end

  AST_CLASS_CODE: assert property (@(posedge clk) disable iff (rst)
    cls != bcast_e'(2'b11)); // R2

endmodule

// File: rtl/pid_qualifier.sv
module pid_qualifier
  import pid_pkg::*;
#(
  parameter int ACQ_CYC = 1000000,
  parameter int REL_CYC = 300000
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   evt,
  input  bcast_e cls,
  output bcast_e status,
  output logic   valid
);

  localparam int LONGEST = (ACQ_CYC > REL_CYC) ? ACQ_CYC : REL_CYC;
  localparam int TMR_W   = $clog2(LONGEST + 1);

  bcast_e           status_q;
  bcast_e           cand_q;
  logic             valid_q;
  logic             pend_q;
  logic [TMR_W-1:0] tmr_q;
  logic [TMR_W-1:0] lim;
  logic             cancel;
  logic             restart;

  assign lim     = (cand_q == MODE_MONO) ? TMR_W'(REL_CYC) : TMR_W'(ACQ_CYC);
  assign cancel  = evt & valid_q & (cls == status_q);
  assign restart = evt & ~cancel & ~(pend_q & (cls == cand_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= MODE_MONO;
      cand_q   <= MODE_MONO;
      valid_q  <= 1'b0;
      pend_q   <= 1'b0;
      tmr_q    <= '0;
    end else if (cancel) begin
      pend_q <= 1'b0;
    end else if (restart) begin
      pend_q <= 1'b1;
      cand_q <= cls;
      tmr_q  <= TMR_W'(1);
    end else if (pend_q) begin
      if (tmr_q == lim) begin
        status_q <= cand_q;
        valid_q  <= 1'b1;
        pend_q   <= 1'b0;
      end else begin
        tmr_q <= tmr_q + TMR_W'(1);
      end
    end
  end

  assign status = status_q;
  assign valid  = valid_q;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (status_q == MODE_MONO && !valid_q)); // R1
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q); // R9
  AST_CHANGE_FROM_PENDING: assert property (@(posedge clk) disable iff (rst)
    !$stable(status_q) |-> ($past(pend_q) || $past(rst))); // R7
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
    status_q != bcast_e'(2'b11)); // R2

endmodule

// File: rtl/pid_tone_classifier.sv
module pid_tone_classifier
  import pid_pkg::*;
#(
  parameter int CLK_HZ        = 1000000,
  parameter int ST_ACQ_LO_HZ  = 140,
  parameter int ST_ACQ_HI_HZ  = 160,
  parameter int ST_HOLD_LO_HZ = 125,
  parameter int ST_HOLD_HI_HZ = 176,
  parameter int BI_ACQ_LO_HZ  = 255,
  parameter int BI_ACQ_HI_HZ  = 300,
  parameter int BI_HOLD_LO_HZ = 237,
  parameter int BI_HOLD_HI_HZ = 312,
  parameter int TIMEOUT_HZ    = 100,
  parameter int ACQ_MS        = 1000,
  parameter int REL_MS        = 300,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tone_in,
  output logic [1:0] bcast_o,
  output logic       valid_o
);

  localparam int TO_CYC  = hz_to_cycles(CLK_HZ, TIMEOUT_HZ);
  localparam int CNT_W   = $clog2(TO_CYC + 1);
  localparam int ACQ_CYC = (CLK_HZ / 1000) * ACQ_MS;
  localparam int REL_CYC = (CLK_HZ / 1000) * REL_MS;

  logic             rise;
  logic             period_evt;
  logic             timeout_evt;
  logic [CNT_W-1:0] period;
  bcast_e           cls;
  bcast_e           status;
  logic             valid;

  pid_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (tone_in),
    .rise (rise)
  );

  pid_period_meter #(.TO_CYC(TO_CYC), .CNT_W(CNT_W)) u_meter (
    .clk         (clk),
    .rst         (rst),
    .rise        (rise),
    .period_evt  (period_evt),
    .timeout_evt (timeout_evt),
    .period      (period)
  );

  pid_band_classifier #(
    .CNT_W(CNT_W), .CLK_HZ(CLK_HZ),
    .ST_ACQ_LO_HZ(ST_ACQ_LO_HZ), .ST_ACQ_HI_HZ(ST_ACQ_HI_HZ),
    .ST_HOLD_LO_HZ(ST_HOLD_LO_HZ), .ST_HOLD_HI_HZ(ST_HOLD_HI_HZ),
    .BI_ACQ_LO_HZ(BI_ACQ_LO_HZ), .BI_ACQ_HI_HZ(BI_ACQ_HI_HZ),
    .BI_HOLD_LO_HZ(BI_HOLD_LO_HZ), .BI_HOLD_HI_HZ(BI_HOLD_HI_HZ)
  ) u_class (
    .clk       (clk),
    .rst       (rst),
    .period    (period),
    .timeout   (timeout_evt),
    .cur_mode  (status),
    .cur_valid (valid),
    .cls       (cls)
  );

  pid_qualifier #(.ACQ_CYC(ACQ_CYC), .REL_CYC(REL_CYC)) u_qual (
    .clk    (clk),
    .rst    (rst),
    .evt    (period_evt | timeout_evt),
    .cls    (cls),
    .status (status),
    .valid  (valid)
  );

  assign bcast_o = status;
  assign valid_o = valid;

endmodule

// File: tb/pid_tone_classifier_bench.sv
`timescale 1ns/1ps
module pid_tone_classifier_bench;

  localparam int CLK_HZ = 32000;
  localparam int TO     = CLK_HZ / 100;
  localparam int ACQ    = (CLK_HZ / 1000) * 250;
  localparam int REL    = (CLK_HZ / 1000) * 75;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tone = 1'b0;
  logic [1:0] bcast;
  logic       valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pid_tone_classifier #(.CLK_HZ(CLK_HZ), .ACQ_MS(250), .REL_MS(75)) u_pid_tone_classifier (
    .clk(clk), .rst(rst), .tone_in(tone), .bcast_o(bcast), .valid_o(valid)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit hist[$];
  int m_cnt, m_armed, m_silent;
  int m_status, m_valid, m_pend, m_cand, m_tmr;

  function automatic bit in_win(int p, int flo, int fhi);
    return (p >= CLK_HZ / fhi) && (p <= CLK_HZ / flo);
  endfunction

  function automatic int classify(int p, bit to, int st, int vld);
    if (to) return 0;
    if (vld != 0 && st == 1) begin
      if (in_win(p, 125, 176)) return 1;
      if (in_win(p, 255, 300)) return 2;
      return 0;
    end
    if (vld != 0 && st == 2) begin
      if (in_win(p, 237, 312)) return 2;
      if (in_win(p, 140, 160)) return 1;
      return 0;
    end
    if (in_win(p, 140, 160)) return 1;
    if (in_win(p, 255, 300)) return 2;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist = '{0, 0, 0, 0};
      m_cnt = 0; m_armed = 0; m_silent = 0;
      m_status = 0; m_valid = 0; m_pend = 0; m_cand = 0; m_tmr = 0;
    end else begin
      bit r, pe, te, ev;
      int c;
      hist.push_front(tone);
      void'(hist.pop_back());
      r  = hist[2] && !hist[3];
      pe = r && (m_armed != 0);
      te = !r && (m_cnt == TO) && (m_silent == 0);
      ev = pe || te;
      c  = classify(m_cnt, te, m_status, m_valid);
      if (r) begin
        m_cnt = 1; m_armed = 1; m_silent = 0;
      end else if (m_cnt == TO) begin
        if (m_silent == 0) begin m_silent = 1; m_armed = 0; end
      end else m_cnt++;
      if (ev && m_valid != 0 && c == m_status) m_pend = 0;
      else if (ev && !(m_pend != 0 && c == m_cand)) begin
        m_pend = 1; m_cand = c; m_tmr = 1;
      end else if (m_pend != 0) begin
        if (m_tmr == ((m_cand == 0) ? REL : ACQ)) begin
          m_status = m_cand; m_valid = 1; m_pend = 0;
        end else m_tmr++;
      end
    end
  end

  // per-cycle comparison against the model (R7 timing, R8, R9)
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(int'(bcast) == m_status, "R7 model status", int'(bcast), m_status);
      chk(int'(valid) == m_valid, "R9 model valid", int'(valid), m_valid);
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_tone(int hi, int lo, int cyc);
    for (int i = 0; i < cyc / (hi + lo); i++) begin
      tone = 1'b1;
      repeat (hi) @(negedge clk);
      tone = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic quiet(int cyc);
    tone = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(bcast == 2'b00 && valid == 1'b0, "R1 reset state", {bcast, valid}, 0);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // no tone: timeout then mono confirmation
    quiet(TO + REL + 40);
    chk(valid == 1'b1 && bcast == 2'b00, "R6 silence gives mono", {bcast, valid}, 1);
    // 150 Hz: period 213
    run_tone(106, 107, ACQ + 1500);
    chk(bcast == 2'b01, "R4 stereo acquired (R2 code 01)", bcast, 1);
    // drift to 128 Hz: period 250, in hold only
    run_tone(125, 125, 4000);
    chk(bcast == 2'b01, "R5 stereo held in hold window", bcast, 1);
    // tone stops
    quiet(1000);
    chk(bcast == 2'b01, "R7 release not yet due", bcast, 1);
    quiet(TO + REL);
    chk(bcast == 2'b00, "R6 absent tone returns mono", bcast, 0);
    // from mono, 128 Hz is outside acquire
    run_tone(125, 125, ACQ + 1500);
    chk(bcast == 2'b00, "R4 hold-only period does not acquire", bcast, 0);
    // 276 Hz: period 116
    run_tone(58, 58, ACQ + 1500);
    chk(bcast == 2'b10, "R4 two-language acquired (R2 code 10)", bcast, 2);
    // short stereo burst then back
    run_tone(106, 107, 3000);
    run_tone(58, 58, 1000);
    chk(bcast == 2'b10, "R8 matching event cancels pending change", bcast, 2);
    // 246 Hz: period 130, hold only
    run_tone(65, 65, 4000);
    chk(bcast == 2'b10, "R5 two-language held in hold window", bcast, 2);
    // two-language to stereo directly
    run_tone(106, 107, 4000);
    chk(bcast == 2'b10, "R7 acquire delay not yet elapsed", bcast, 2);
    run_tone(106, 107, 6000);
    chk(bcast == 2'b01, "R5 two-language to stereo", bcast, 1);
    // reset mid-run
    do_reset();
    // boundary: period 229 (just below 140 Hz limit) stays mono
    run_tone(114, 115, ACQ + 1500);
    chk(bcast == 2'b00, "R3 period 229 outside acquire", bcast, 0);
    // boundary: period 200 (exactly 160 Hz) acquires stereo
    run_tone(100, 100, ACQ + 1500);
    chk(bcast == 2'b01 && valid == 1'b1, "R3 period 200 inside acquire", bcast, 1);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

endmodule